// File: doc/BRIEF.md
# Bus Error Status Latch

This block watches every transfer on an on-chip bus and keeps a record of the first error event it sees. Two kinds of event are recorded. One is a transfer answered with an ERROR response, which the memory gives for a fault it cannot correct. The other is a read that the memory marks with its "corrected" sideband, meaning the data was repaired on the fly. On the first such event the block captures the transfer address and sets status flags. It also notes the direction and size of the transfer and sends one pulse on an interrupt line.

After that the record is frozen. Later events pass by unrecorded until software reads the status and failing-address registers through a small register port and then writes the status register with its new-error flag at zero. That write re-arms the latch. A scrubbing routine can use the captured address to rewrite a location whose error was corrected. An uncorrectable record, whose correctable flag is clear, tells the handler that the data was lost.

Top module: `bus_err_latch`

## Requirements
- R1: A valid read that carries the corrected sideband while the latch is empty sets the new-error flag (status bit 8) and the correctable flag (status bit 9), and captures the transfer address. The result is visible after the next clock edge.
- R2: A valid transfer with an ERROR response while the latch is empty sets bit 8, clears bit 9 and captures the address. When ERROR and the corrected sideband arrive together, ERROR wins.
- R3: While bit 8 is set, further events change no status bit and no address bit, and they raise no interrupt.
- R4: A register write to offset 0 with wdata bit 8 at zero clears the whole status word and re-arms the latch. A write to offset 0 with bit 8 at one, or a write to offset 4, has no effect.
- R5: The interrupt output is high for exactly the one cycle after the edge that set bit 8, and at no other time.
- R6: The recorded status holds the direction of the failing transfer in bit 3 (1 = write) and the transfer size code in bits 2:0.
- R7: If an event and a clearing write fall in the same cycle, the clear wins. The event is lost, bit 8 stays zero and no interrupt is raised.
- R8: Register reads are combinational. Offset 0 returns the status word, offset 4 returns the failing address, and any other offset returns zero.
- R9: The corrected sideband is ignored on a write transfer. Every event input is ignored while the transfer-valid input is low.
- R10: After reset the status word, the failing address and the interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_valid | input | 1 | A transfer completes this cycle |
| mon_addr | input | ADDR_W | Address of the transfer |
| mon_write | input | 1 | 1 = write transfer, 0 = read |
| mon_size | input | 3 | Transfer size code |
| mon_err | input | 1 | ERROR response on this transfer |
| mon_corr | input | 1 | Memory corrected-data sideband |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = register write |
| reg_ofs | input | OFS_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| status_o | output | DATA_W | Current status word |
| fail_addr_o | output | ADDR_W | Captured failing address |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit data word and a 4-bit register offset. With these, full-width random addresses let any single stuck or swapped capture bit show up. The 4-bit offset also covers unmapped offsets such as 8 and 12. Random mixes of ERROR, corrected and write transfers, with clearing writes scattered among them, drive the latch through armed, frozen and re-armed phases many times. Directed steps place a clear in the same cycle as an event and send ERROR and the corrected sideband together.

// File: rtl/berr_pkg.sv
package berr_pkg;
    localparam int SIZE_W = 3;
    localparam int WR_BIT = 3;
    localparam int NE_BIT = 8;
    localparam int CE_BIT = 9;
    localparam int OFS_STATUS = 0;
    localparam int OFS_FADDR  = 4;
endpackage

// File: rtl/berr_classify.sv
module berr_classify (
    input  logic valid_i,
    input  logic write_i,
    input  logic err_i,
    input  logic corr_i,
    output logic evt_o,
    output logic evt_ce_o
);
    logic hard_evt;
    logic soft_evt;

    always_comb begin
        hard_evt = valid_i && err_i;
        soft_evt = valid_i && corr_i && !write_i;
        evt_o    = hard_evt || soft_evt;
        evt_ce_o = soft_evt && !hard_evt;
    end
endmodule

// File: rtl/berr_regif.sv
module berr_regif #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic              en_i,
    input  logic              we_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [ADDR_W-1:0] faddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clr_o
);
    import berr_pkg::*;

    localparam logic [OFS_W-1:0] SEL_STAT = OFS_W'(OFS_STATUS);
    localparam logic [OFS_W-1:0] SEL_ADDR = OFS_W'(OFS_FADDR);

    always_comb begin
        clr_o = en_i && we_i && (ofs_i == SEL_STAT) && !wdata_i[NE_BIT];
        if (ofs_i == SEL_STAT)      rdata_o = status_i;
        else if (ofs_i == SEL_ADDR) rdata_o = DATA_W'(faddr_i);
        else                        rdata_o = '0;
    end
endmodule

// File: rtl/bus_err_latch.sv
module bus_err_latch #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              mon_write,
    input  logic [2:0]        mon_size,
    input  logic              mon_err,
    input  logic              mon_corr,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] status_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic              irq_o
);
    import berr_pkg::*;

    typedef struct packed {
        logic              ne;
        logic              ce;
        logic              wr;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic              irq;
    } latch_t;

    latch_t st_d, st_q;
    logic   evt, evt_ce, clr;

    berr_classify i_classify (
        .valid_i (mon_valid),
        .write_i (mon_write),
        .err_i   (mon_err),
        .corr_i  (mon_corr),
        .evt_o   (evt),
        .evt_ce_o(evt_ce)
    );

    berr_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) i_regif (
        .en_i    (reg_en),
        .we_i    (reg_we),
        .ofs_i   (reg_ofs),
        .wdata_i (reg_wdata),
        .status_i(status_o),
        .faddr_i (fail_addr_o),
        .rdata_o (reg_rdata),
        .clr_o   (clr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (clr) begin
            st_d.ne   = 1'b0;
            st_d.ce   = 1'b0;
            st_d.wr   = 1'b0;
            st_d.size = '0;
        end else if (evt && !st_q.ne) begin
            st_d.ne   = 1'b1;
            st_d.ce   = evt_ce;
            st_d.wr   = mon_write;
            st_d.size = mon_size;
            st_d.addr = mon_addr;
            st_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o             = '0;
        status_o[SIZE_W-1:0] = st_q.size;
        status_o[WR_BIT]     = st_q.wr;
        status_o[NE_BIT]     = st_q.ne;
        status_o[CE_BIT]     = st_q.ce;
        fail_addr_o          = st_q.addr;
        irq_o                = st_q.irq;
    end

    // R3: a frozen record keeps its address
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ne && !clr) |=> $stable(fail_addr_o));
    // R3: a frozen record keeps its flags
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ne && !clr) |=> $stable(status_o));
    // R5: pulse lasts one cycle
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R5: pulse only on the edge that set the new-error flag
    a_r5_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.ne && !$past(st_q.ne)));
    // R7: clear wins over a simultaneous event
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!st_q.ne && !irq_o));
    // R2: an uncorrectable event leaves the correctable flag clear
    a_r2_err_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ne && evt && !evt_ce && !clr) |=> (st_q.ne && !st_q.ce));
endmodule

// File: tb/test_bus_err_latch.sv
module test_bus_err_latch;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_valid = 0, mon_write = 0, mon_err = 0, mon_corr = 0;
    logic [AW-1:0] mon_addr = '0;
    logic [2:0]    mon_size = '0;
    logic          reg_en = 0, reg_we = 0;
    logic [OW-1:0] reg_ofs = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata, status_o;
    logic [AW-1:0] fail_addr_o;
    logic          irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // expected model
    logic          m_ne = 0, m_ce = 0, m_wr = 0, m_irq = 0;
    logic [2:0]    m_size = '0;
    logic [AW-1:0] m_addr = '0;

    always #4 clk = ~clk;

    bus_err_latch #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW)) i_bus_err_latch (
        .clk(clk), .rst_n(rst_n),
        .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_write(mon_write),
        .mon_size(mon_size), .mon_err(mon_err), .mon_corr(mon_corr),
        .reg_en(reg_en), .reg_we(reg_we), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .status_o(status_o), .fail_addr_o(fail_addr_o),
        .irq_o(irq_o)
    );

    function automatic logic [DW-1:0] exp_status();
        logic [DW-1:0] s = '0;
        s[2:0] = m_size;
        s[3]   = m_wr;
        s[8]   = m_ne;
        s[9]   = m_ce;
        return s;
    endfunction

    function automatic logic [DW-1:0] exp_rdata(logic [OW-1:0] ofs);
        if (ofs == 0) return exp_status();
        if (ofs == 4) return DW'(m_addr);
        return '0;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "status", 64'(status_o), 64'(exp_status()));
        check(req, "fail_addr", 64'(fail_addr_o), 64'(m_addr));
        check(req, "irq", 64'(irq_o), 64'(m_irq));
        check(req, "rdata", 64'(reg_rdata), 64'(exp_rdata(reg_ofs)));
    endtask

    // apply inputs at negedge, update model, sample 2 ns after posedge
    task automatic step(string req, logic v, logic [AW-1:0] a, logic w, logic [2:0] sz,
                        logic e, logic c, logic ren, logic rwe, logic [OW-1:0] ofs,
                        logic [DW-1:0] wd);
        logic clr, evt, ce;
        @(negedge clk);
        mon_valid = v; mon_addr = a; mon_write = w; mon_size = sz;
        mon_err = e; mon_corr = c;
        reg_en = ren; reg_we = rwe; reg_ofs = ofs; reg_wdata = wd;
        clr = ren && rwe && (ofs == 0) && !wd[8];
        evt = v && (e || (c && !w));
        ce  = v && !e && c && !w;
        m_irq = 1'b0;
        if (clr) begin
            m_ne = 0; m_ce = 0; m_wr = 0; m_size = '0;
        end else if (evt && !m_ne) begin
            m_ne = 1; m_ce = ce; m_wr = w; m_size = sz; m_addr = a; m_irq = 1;
        end
        @(posedge clk);
        #2;
        check_all(req);
    endtask

    task automatic idle(string req, logic [OW-1:0] ofs);
        step(req, 0, '0, 0, 0, 0, 0, 0, 0, ofs, '0);
    endtask

    task automatic clear(string req);
        step(req, 0, '0, 0, 0, 0, 0, 1, 1, 0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #2;
        check_all("R10");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 corrected read captured
        step("R1", 1, 32'hA5A5_1230, 0, 3'd2, 0, 1, 0, 0, 0, '0);
        // R5 pulse dropped next cycle; R8 read address through offset 4
        idle("R5", 4);
        // R3 later error ignored
        step("R3", 1, 32'h1111_2222, 1, 3'd1, 1, 0, 0, 0, 0, '0);
        // R4 write with bit 8 set, and write to offset 4: no effect
        step("R4", 0, '0, 0, 0, 0, 0, 1, 1, 0, 32'h0000_0100);
        step("R4", 0, '0, 0, 0, 0, 0, 1, 1, 4, 32'h0);
        clear("R4");
        // R2 error with corrected together on write: ERROR, CE clear; R6 write+size
        step("R2", 1, 32'hDEAD_BEE0, 1, 3'd3, 1, 1, 0, 0, 0, '0);
        step("R6", 0, '0, 0, 0, 0, 0, 0, 0, 8, '0);
        clear("R4");
        // R9 corrected on write, and events without valid
        step("R9", 1, 32'h0BAD_0000, 1, 3'd2, 0, 1, 0, 0, 0, '0);
        step("R9", 0, 32'h0BAD_0004, 0, 3'd2, 1, 1, 0, 0, 0, '0);
        // R7 event and clear in the same cycle
        step("R7", 1, 32'h7777_0000, 0, 3'd2, 1, 0, 1, 1, 0, '0);
        idle("R7", 0);
        // R8 unmapped offset
        idle("R8", 12);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic doclr = (r[7:0] < 8'd20);
            step("R1", r[8] | r[9], $urandom, r[10], r[13:11], r[18:15] == 0,
                 r[20:19] == 0, doclr | r[21], doclr, doclr ? 4'd0 : OW'({r[23:22], 2'b00}),
                 doclr ? 32'h0 : DW'(r[24]) << 8);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule